// File: doc/BRIEF.md
# Bus Transaction Timeout Monitor

This block sits beside one bus master and times each transaction. A transaction starts when the request line rises and ends when ready is seen with the request held. A free-running prescaler divides the block clock by one of three powers of two. A tick counter counts the prescaled ticks that fall inside the current transaction. When the count reaches the configured limit, the monitor raises a one-cycle abort pulse and sets a sticky timeout flag. Software clears the flag by writing one to a clear input.

Two fields set the limit. The first is a 2-bit prescale code. Code 0 turns the monitor off, and codes 1 to 3 pick the divider. The second is a 3-bit tick code that picks a power-of-two tick count. The prescaler is never re-phased at the start of a transaction, so the first tick can come early. The real timeout therefore lies between N-1 and N prescaled periods.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset, `timeout_flag` and `abort` are both 0.
- R2: A prescaler counts clock cycles from reset without ever stopping. In the cycle in which the prescaler holds value v, a tick occurs when v mod 2^S equals 2^S-1. S is `SH1`, `SH2` or `SH3` for `ps_sel` equal to 1, 2 or 3 (default 8, 16, 24).
- R3: A cycle is waiting when `req`=1 and `rdy`=0. The limit is N = 4 << `tick_sel` ticks, so the codes 0..7 give 4..512. If the Nth tick counted in waiting cycles of one transaction falls in cycle c, `abort` is 1 in cycle c+1.
- R4: With `ps_sel`=0, no tick is counted and `abort` and `timeout_flag` never rise.
- R5: A cycle with `req`=0 or `rdy`=1 returns the tick count to zero. A transaction that completes before its Nth tick raises no abort, and the next transaction counts from zero again.
- R6: `abort` lasts exactly one cycle and fires at most once per transaction, however long the request is then held.
- R7: `timeout_flag` becomes 1 in the same cycle as `abort` and stays 1 until `flag_clr`=1 is seen on a clock edge. It is 0 from the next cycle, unless an abort is being raised at that same edge, in which case it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Master request, held until ready |
| rdy | input | 1 | Slave ready, completes the transaction |
| ps_sel | input | 2 | Prescale code: 0 off, 1..3 divider select |
| tick_sel | input | 3 | Tick-count code, limit = 4 << code |
| flag_clr | input | 1 | Write-one-to-clear for the timeout flag |
| timeout_flag | output | 1 | Sticky timeout indication |
| abort | output | 1 | One-cycle pulse when a timeout is detected |

## Verification
The bench keeps its own count of cycles since reset. This count equals the prescaler value, so the bench can work out for each transaction which cycle holds the Nth tick. The abort pulse is then due exactly one cycle later. A flag clear takes effect one cycle after the clear is sampled.

The driver queues the cycle in which each abort is due. The monitor samples on the falling edge and compares each abort against the head of that queue. An abort that arrives when nothing is queued counts as a failure, and so does an entry still left in the queue at the end.

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon #(
  parameter int SH1 = 8,
  parameter int SH2 = 16,
  parameter int SH3 = 24,
  parameter int CW  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       rdy,
  input  logic [1:0] ps_sel,
  input  logic [2:0] tick_sel,
  input  logic       flag_clr,
  output logic       timeout_flag,
  output logic       abort
);
  localparam int PW = SH3;

  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          fired;
  logic          tick;
  logic          waiting;
  logic          hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  always_comb
    case (ps_sel)
      2'd1:    tick = &pre[SH1-1:0];
      2'd2:    tick = &pre[SH2-1:0];
      2'd3:    tick = &pre[SH3-1:0];
      default: tick = 1'b0;
    endcase

  assign waiting = req & ~rdy;
  assign last    = (CW'(4) << tick_sel) - CW'(1);
  assign hit     = waiting & tick & ~fired & (cnt == last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!waiting) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      if (tick && !fired) cnt <= cnt + 1'b1;
      if (hit) fired <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      abort        <= 1'b0;
      timeout_flag <= 1'b0;
    end else begin
      abort        <= hit;
      timeout_flag <= hit | (timeout_flag & ~flag_clr);
    end

  assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  assert_flag_with_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> timeout_flag);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !flag_clr) |=> timeout_flag);
  assert_flag_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> abort);
  assert_off_no_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_sel == 2'd0) |=> !abort);
  assert_done_no_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || rdy) |=> !abort);
endmodule

// File: tb/test_bus_timeout_mon.sv
module test_bus_timeout_mon;
  localparam int S1 = 2, S2 = 3, S3 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, rdy = 1'b0, flag_clr = 1'b0;
  logic [1:0] ps_sel = 2'd0;
  logic [2:0] tick_sel = 3'd0;
  logic timeout_flag, abort;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_q[$];
  bit done = 1'b0;

  bus_timeout_mon #(.SH1(S1), .SH2(S2), .SH3(S3)) i_bus_timeout_mon (
    .clk(clk), .rst_n(rst_n), .req(req), .rdy(rdy), .ps_sel(ps_sel),
    .tick_sel(tick_sel), .flag_clr(flag_clr),
    .timeout_flag(timeout_flag), .abort(abort));

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  function automatic int nth_tick(int s, int ps, int ts);
    int p  = 1 << ((ps == 1) ? S1 : (ps == 2) ? S2 : S3);
    int t1 = s + (p - 1 - (s % p));
    return t1 + ((4 << ts) - 1) * p;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done && abort) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4/R5/R6 unexpected abort actual=1 expected=0 (cycle %0d)", cyc);
      end else begin
        chk("R3 abort cycle", cyc, exp_q.pop_front());
        chk("R7 flag with abort", int'(timeout_flag), 1);
      end
    end
  end

  task automatic txn(int ps, int ts, int len);
    int s, vn;
    @(negedge clk);
    ps_sel = 2'(ps); tick_sel = 3'(ts); req = 1'b1; rdy = 1'b0;
    s = cyc;
    vn = (ps == 0) ? 32'h7fffffff : nth_tick(s, ps, ts);
    if (len < 0) len = vn - s;
    if (ps != 0 && vn < s + len) exp_q.push_back(vn + 1);
    repeat (len) @(negedge clk);
    rdy = 1'b1;
    @(negedge clk);
    req = 1'b0; rdy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_flag;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int s, vn;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag after reset", int'(timeout_flag), 0);
    chk("R1 abort after reset", int'(abort), 0);

    // R3 R2: shortest limit, divider 1
    txn(1, 0, 40);
    repeat (3) @(negedge clk);
    chk("R7 flag sticky", int'(timeout_flag), 1);
    clear_flag();
    chk("R7 flag cleared", int'(timeout_flag), 0);

    // R2 R3: other dividers and limits, shifted phases
    repeat (3) @(negedge clk);
    txn(2, 3, 400);
    repeat (5) @(negedge clk);
    txn(3, 7, 9000);
    txn(1, 5, 200);
    clear_flag();

    // R4: monitor off
    txn(0, 7, 3000);
    txn(0, 0, 300);
    chk("R4 flag stays clear", int'(timeout_flag), 0);
    chk("R4 no abort queued", exp_q.size(), 0);

    // R5: complete in the Nth-tick cycle, then a fresh count
    txn(1, 2, -1);
    chk("R5 no flag on early completion", int'(timeout_flag), 0);
    @(negedge clk);
    txn(1, 2, 100);
    clear_flag();

    // R6: held far past the limit, one abort only
    txn(1, 0, 300);
    chk("R6 queue drained", exp_q.size(), 0);
    clear_flag();
    chk("R7 flag cleared again", int'(timeout_flag), 0);

    // R7: clear in the same cycle as the hit, set wins
    @(negedge clk);
    ps_sel = 2'd1; tick_sel = 3'd1; req = 1'b1; rdy = 1'b0;
    s = cyc;
    vn = nth_tick(s, 1, 1);
    exp_q.push_back(vn + 1);
    while (cyc != vn) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R7 set wins over clear", int'(timeout_flag), 1);
    @(negedge clk);
    chk("R7 flag held after collision", int'(timeout_flag), 1);
    rdy = 1'b1;
    @(negedge clk);
    req = 1'b0; rdy = 1'b0;
    repeat (3) @(negedge clk);

    chk("R3 all expected aborts seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule